// File: doc/BRIEF.md
# Interrupt Acknowledge Vector Acquisition Unit

This unit carries out the acknowledge bus cycle for an interrupt level that the core has already accepted. When it is started with a nonzero level, it opens the acknowledge cycle and presents that level to the bus. It then waits for the interrupting side to end the cycle in one of three ways:

- The device returns its own 8-bit vector together with a data acknowledge.
- The device asks for an autovector.
- The bus signals an error.

If nothing answers within a set number of cycles, the unit treats the silence as a bus error.

From the way the cycle ended, the unit produces three results and hands them to the stacking and vector-fetch logic in a one-cycle done pulse:

- the final vector number;
- the vector table address, which is the vector times four;
- the 16-bit format/offset word for the short exception frame.

A bus error does not lead to the bus-error vector. It selects a separate spurious-interrupt vector. A device that was never programmed answers with vector 15, and the unit passes that value through untouched.

Top module: `irqack_vector_unit`

## Requirements
- R1: While reset is high and on the first cycle after it, `ack_cycle`, `done`, `vec_num`, `vec_addr` and `fmt_word` are all zero.
- R2: While idle, a `start` pulse with `level` from 1 to 7 raises `ack_cycle` on the next clock and latches `ack_level` = `level`. A `start` with `level` 0 is ignored. A `start` that arrives while `ack_cycle` is high changes neither `ack_level` nor the result.
- R3: A data acknowledge (`dev_dtack`) alone ends the cycle with `vec_num` equal to `dev_vector`, unchanged. This includes the uninitialized-device code 0x0F (15).
- R4: An autovector request (`dev_autovec`) without a bus error ends the cycle with `vec_num` = 24 + `ack_level`, which lies in the range 25 to 31.
- R5: A bus error (`dev_berr`) ends the cycle with `vec_num` = 24, the spurious-interrupt vector.
- R6: When more than one termination input is high in the same cycle, bus error wins over autovector, and autovector wins over data acknowledge.
- R7: If no termination input is seen for TIMEOUT_CYCLES active cycles, the cycle ends with `vec_num` = 24. In that case `ack_cycle` stays high for exactly TIMEOUT_CYCLES cycles.
- R8: `done` is high for exactly one cycle, on the clock after the terminating cycle. `ack_cycle` is low in that same cycle. `vec_num`, `vec_addr` and `fmt_word` hold their values after `done` falls.
- R9: `vec_addr` = `vec_num` × 4 (10 bits). `fmt_word` carries a zero format field in bits 15:12 and `vec_num` × 4 in bits 11:0.
- R10: Termination inputs that arrive while `ack_cycle` is low produce no `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an acknowledge cycle for `level` |
| level | input | 3 | Accepted interrupt level |
| dev_dtack | input | 1 | Data acknowledge from the device |
| dev_vector | input | 8 | Vector returned by the device |
| dev_autovec | input | 1 | Autovector request |
| dev_berr | input | 1 | Bus error |
| ack_cycle | output | 1 | Acknowledge cycle in progress |
| ack_level | output | 3 | Level presented during the acknowledge cycle |
| done | output | 1 | One-cycle result strobe |
| vec_num | output | 8 | Final vector number |
| vec_addr | output | 10 | Vector table address (vector × 4) |
| fmt_word | output | 16 | Format/offset word for the short frame |

## Verification
The assertions check the following on every cycle:

- the presented level is nonzero and stays stable during the cycle;
- the timeout counter stays bounded;
- `done` is a single-cycle pulse that only follows an active cycle;
- a bus error, an autovector or a lone data acknowledge in the terminating cycle yields the matching vector.

Some behaviours show only in the bench's scenarios:

- the exact length of the acknowledge cycle under a timeout;
- the way `start` is ignored at level 0 or while busy;
- termination inputs being ignored while idle;
- the values holding after the pulse;
- the address and format/offset word layouts.

// File: rtl/irqack_pkg.sv
package irqack_pkg;
  typedef enum logic {ST_IDLE, ST_ACK} ack_state_e;

  // Spurious-interrupt vector and base of the autovector range
  localparam int unsigned SPURIOUS_VEC = 24;
  localparam int unsigned AUTOVEC_BASE = 24;
endpackage

// File: rtl/irqack_resolver.sv
module irqack_resolver
  import irqack_pkg::*;
#(
  parameter int VEC_W = 8,
  parameter int LVL_W = 3
) (
  input  logic             term_berr,
  input  logic             term_autovec,
  input  logic             term_dtack,
  input  logic             term_expire,
  input  logic [LVL_W-1:0] cur_level,
  input  logic [VEC_W-1:0] dev_vec,
  output logic             hit,
  output logic [VEC_W-1:0] vector
);
  // Fixed priority: bus error, then autovector, then data acknowledge.
  // Timeout falls through to the spurious vector.
  always_comb begin
    hit    = term_berr | term_autovec | term_dtack | term_expire;
    vector = VEC_W'(SPURIOUS_VEC);
    if (term_berr)
      vector = VEC_W'(SPURIOUS_VEC);
    else if (term_autovec)
      vector = VEC_W'(AUTOVEC_BASE) + VEC_W'(cur_level);
    else if (term_dtack)
      vector = dev_vec;
  end
endmodule

// File: rtl/irqack_timer.sv
module irqack_timer #(
  parameter int TIMEOUT_CYCLES = 16,
  localparam int CNT_W = $clog2(TIMEOUT_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic expire
);
  logic [CNT_W-1:0] cnt;

  assign expire = run && (cnt == CNT_W'(TIMEOUT_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (rst || !run)
      cnt <= '0;
    else if (!expire)
      cnt <= cnt + 1'b1;
  end

  // R7: the count never passes the last allowed cycle while running
  a_r7_count_bounded: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt < CNT_W'(TIMEOUT_CYCLES)));
endmodule

// File: rtl/irqack_frame_fmt.sv
module irqack_frame_fmt #(
  parameter int VEC_W      = 8,
  parameter int FMT_WORD_W = 16,
  parameter int FMT_W      = 4,
  localparam int OFS_W     = FMT_WORD_W - FMT_W,
  localparam int ADDR_W    = VEC_W + 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  load,
  input  logic [VEC_W-1:0]      vector,
  output logic                  done,
  output logic [VEC_W-1:0]      vec_num,
  output logic [ADDR_W-1:0]     vec_addr,
  output logic [FMT_WORD_W-1:0] fmt_word
);
  logic [ADDR_W-1:0] scaled;
  assign scaled = {vector, 2'b00};

  always_ff @(posedge clk) begin
    if (rst) begin
      done     <= 1'b0;
      vec_num  <= '0;
      vec_addr <= '0;
      fmt_word <= '0;
    end else begin
      done <= load;
      if (load) begin
        vec_num  <= vector;
        vec_addr <= scaled;
        fmt_word <= {FMT_W'(0), OFS_W'(scaled)};
      end
    end
  end

  // R8: the result strobe lasts a single cycle
  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: rtl/irqack_vector_unit.sv
module irqack_vector_unit
  import irqack_pkg::*;
#(
  parameter int VEC_W          = 8,
  parameter int LVL_W          = 3,
  parameter int FMT_WORD_W     = 16,
  parameter int TIMEOUT_CYCLES = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic [LVL_W-1:0]      level,
  input  logic                  dev_dtack,
  input  logic [VEC_W-1:0]      dev_vector,
  input  logic                  dev_autovec,
  input  logic                  dev_berr,
  output logic                  ack_cycle,
  output logic [LVL_W-1:0]      ack_level,
  output logic                  done,
  output logic [VEC_W-1:0]      vec_num,
  output logic [VEC_W+1:0]      vec_addr,
  output logic [FMT_WORD_W-1:0] fmt_word
);
  ack_state_e       state;
  logic             active, expire, hit, load;
  logic [VEC_W-1:0] sel_vec;

  assign active    = (state == ST_ACK);
  assign ack_cycle = active;
  assign load      = active && hit;

  irqack_timer #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .run(active), .expire(expire)
  );

  irqack_resolver #(.VEC_W(VEC_W), .LVL_W(LVL_W)) u_resolve (
    .term_berr(dev_berr), .term_autovec(dev_autovec), .term_dtack(dev_dtack),
    .term_expire(expire), .cur_level(ack_level), .dev_vec(dev_vector),
    .hit(hit), .vector(sel_vec)
  );

  irqack_frame_fmt #(.VEC_W(VEC_W), .FMT_WORD_W(FMT_WORD_W)) u_fmt (
    .clk(clk), .rst(rst), .load(load), .vector(sel_vec),
    .done(done), .vec_num(vec_num), .vec_addr(vec_addr), .fmt_word(fmt_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      ack_level <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start && level != '0) begin
          state     <= ST_ACK;
          ack_level <= level;
        end
        ST_ACK: if (hit) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2: a nonzero level is presented and held for the whole cycle
  a_r2_level_nonzero: assert property (@(posedge clk) disable iff (rst)
    ack_cycle |-> (ack_level != '0));
  a_r2_level_stable: assert property (@(posedge clk) disable iff (rst)
    (ack_cycle && $past(ack_cycle)) |-> $stable(ack_level));
  // R10: a result only follows an active acknowledge cycle
  a_r10_done_after_ack: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(ack_cycle) && !ack_cycle));
  // R5: bus error selects the spurious vector
  a_r5_berr_spurious: assert property (@(posedge clk) disable iff (rst)
    (done && $past(dev_berr && ack_cycle)) |-> (vec_num == VEC_W'(SPURIOUS_VEC)));
  // R4, R6: autovector beats data acknowledge
  a_r4_autovector: assert property (@(posedge clk) disable iff (rst)
    (done && $past(dev_autovec && !dev_berr && ack_cycle))
      |-> (vec_num == VEC_W'(AUTOVEC_BASE) + VEC_W'($past(ack_level))));
  // R3: a lone data acknowledge passes the device vector through
  a_r3_dtack_pass: assert property (@(posedge clk) disable iff (rst)
    (done && $past(dev_dtack && !dev_autovec && !dev_berr && ack_cycle))
      |-> (vec_num == $past(dev_vector)));
endmodule

// File: tb/irqack_vector_unit_test.sv
`timescale 1ns/1ps
module irqack_vector_unit_test;
  localparam int TO = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [2:0] level = '0;
  logic       dev_dtack = 1'b0, dev_autovec = 1'b0, dev_berr = 1'b0;
  logic [7:0] dev_vector = '0;
  logic       ack_cycle, done;
  logic [2:0] ack_level;
  logic [7:0] vec_num;
  logic [9:0] vec_addr;
  logic [15:0] fmt_word;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  irqack_vector_unit #(.TIMEOUT_CYCLES(TO)) uut (
    .clk(clk), .rst(rst), .start(start), .level(level),
    .dev_dtack(dev_dtack), .dev_vector(dev_vector), .dev_autovec(dev_autovec),
    .dev_berr(dev_berr), .ack_cycle(ack_cycle), .ack_level(ack_level),
    .done(done), .vec_num(vec_num), .vec_addr(vec_addr), .fmt_word(fmt_word)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_vec(bit resp, bit b, bit a, int lvl, logic [7:0] v);
    if (!resp || b) return 8'd24;
    if (a) return 8'(24 + lvl);
    return v;
  endfunction

  task automatic clear_resp();
    dev_berr = 0; dev_autovec = 0; dev_dtack = 0;
  endtask

  // One acknowledge cycle; response driven during active cycle d
  task automatic run_case(int lvl, int d, bit b, bit a, bit t, logic [7:0] v);
    bit resp;
    int kend;
    int cyc;
    string req;
    logic [7:0] ev;
    resp = (d < TO) && (b || a || t);
    kend = resp ? d : TO - 1;
    ev = exp_vec(resp, b, a, lvl, v);
    if (!resp) req = "R7";
    else if (int'(b) + int'(a) + int'(t) > 1) req = "R6";
    else if (b) req = "R5";
    else if (a) req = "R4";
    else req = "R3";
    @(negedge clk); start = 1; level = 3'(lvl);
    @(negedge clk); start = 0; level = 3'(lvl + 3);
    chk("R2", "ack_cycle", 32'(ack_cycle), 1);
    chk("R2", "ack_level", 32'(ack_level), 32'(lvl));
    cyc = 0;
    while (!done && cyc < 100) begin
      if (cyc == d) begin
        dev_berr = b; dev_autovec = a; dev_dtack = t; dev_vector = v;
      end else begin
        clear_resp();
        dev_vector = 8'($urandom);
      end
      @(negedge clk);
      cyc++;
    end
    clear_resp();
    chk(req, "latency", 32'(cyc), 32'(kend + 1));
    chk("R8", "done", 32'(done), 1);
    chk("R8", "ack_low_at_done", 32'(ack_cycle), 0);
    chk(req, "vec_num", 32'(vec_num), 32'(ev));
    chk("R9", "vec_addr", 32'(vec_addr), 32'({ev, 2'b00}));
    chk("R9", "fmt_word", 32'(fmt_word), 32'({4'h0, 2'b00, ev, 2'b00}));
    @(negedge clk);
    chk("R8", "done_fell", 32'(done), 0);
    chk("R8", "vec_hold", 32'(vec_num), 32'(ev));
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int seed_set;
    seed_set = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    chk("R1", "ack_cycle_in_reset", 32'(ack_cycle), 0);
    chk("R1", "done_in_reset", 32'(done), 0);
    rst = 0;
    @(negedge clk);
    chk("R1", "ack_cycle", 32'(ack_cycle), 0);
    chk("R1", "done", 32'(done), 0);
    chk("R1", "vec_num", 32'(vec_num), 0);
    chk("R1", "vec_addr", 32'(vec_addr), 0);
    chk("R1", "fmt_word", 32'(fmt_word), 0);

    // R2: level 0 start is ignored
    start = 1; level = 0;
    @(negedge clk); start = 0;
    chk("R2", "level0_ignored", 32'(ack_cycle), 0);
    @(negedge clk);
    chk("R2", "level0_no_done", 32'(done), 0);

    // R10: termination inputs while idle
    dev_berr = 1; dev_dtack = 1; dev_autovec = 1;
    @(negedge clk);
    @(negedge clk);
    clear_resp();
    chk("R10", "idle_done", 32'(done), 0);
    chk("R10", "idle_vec", 32'(vec_num), 0);

    // Directed corner cases
    run_case(5, 2, 0, 0, 1, 8'h0F);   // R3 uninitialized vector 15
    run_case(7, 0, 0, 1, 0, 8'h55);   // R4 level 7 -> 31
    run_case(1, 3, 0, 1, 0, 8'h00);   // R4 level 1 -> 25
    run_case(3, 1, 1, 0, 0, 8'h80);   // R5
    run_case(4, 0, 1, 1, 1, 8'h99);   // R6 all three
    run_case(6, 2, 0, 1, 1, 8'h99);   // R6 autovec over dtack
    run_case(2, TO + 5, 0, 0, 0, 8'h00); // R7 timeout
    run_case(2, TO - 1, 0, 0, 1, 8'hC4); // R3 at last allowed cycle

    // R2: start while busy is ignored
    @(negedge clk); start = 1; level = 3'd2;
    @(negedge clk); start = 1; level = 3'd6;
    @(negedge clk); start = 0;
    chk("R2", "busy_start_level", 32'(ack_level), 2);
    dev_dtack = 1; dev_vector = 8'h40;
    @(negedge clk); clear_resp();
    chk("R2", "busy_start_result", 32'(vec_num), 32'h40);
    @(negedge clk);
    chk("R2", "busy_start_idle", 32'(ack_cycle), 0);

    // Constrained random mix
    for (int i = 0; i < 80; i++) begin
      int lvl;
      int d;
      bit b, a, t;
      lvl = 1 + int'($urandom_range(0, 6));
      d = int'($urandom_range(0, TO + 2));
      b = ($urandom_range(0, 3) == 0);
      a = ($urandom_range(0, 2) == 0);
      t = ($urandom_range(0, 1) == 0);
      run_case(lvl, d, b, a, t, 8'($urandom));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule